// File: doc/BRIEF.md
# Sleep Output-Disable Delay Timer

This power-management block switches off a group of bus output drivers some programmable number of slow timing-clock edges after the system enters suspend. Software programs a single 32-bit control word over a small register bus. The word holds a delay count, an enable bit and one spare bit. The slow timing clock nominally runs at 3.57954 MHz. It reaches the block as a one-cycle enable strobe in the main clock domain, so the whole design sits on one clock.

A falling edge on the active-low suspend input arms the timer. The timer takes a snapshot of the delay and the enable. It also checks whether the sleep-clock-stop logic would stop the clocks before this delay expires. If clock stop is enabled and its delay is shorter than this block's delay, the timer never turns the drivers off during that suspend period. Otherwise it counts slow-clock strobes and drops the output-enable once the count matches. The output-enable returns high combinationally as soon as suspend deasserts.

Top module: `sleep_out_disable_timer`

## Requirements
- R1: While reset is high and after it, before any write: `out_en` is 1 and a read at the control offset returns 0.
- R2: The control word sits at byte address 0x0C. A write there stores all 32 bits, including the spare bit 31, and a read there returns them unchanged. A read at any other address returns 0, and a write at any other address leaves the word unchanged.
- R3: With enable bit 30 set and delay D in bits [29:0], suppose `susp_n` is first sampled low at clock edge E. Strobes sampled at later edges are counted, and `out_en` goes low right after the edge that samples the (D+1)-th counted strobe. A strobe sampled at edge E itself is not counted.
- R4: With D = 0, the first counted strobe after the suspend edge disables the outputs.
- R5: If bit 30 is 0 when the suspend edge is sampled, `out_en` stays 1 for that whole suspend period.
- R6: If `cs_en` is 1 at the suspend edge and D is strictly greater than `cs_delay`, `out_en` stays 1 for that suspend period. If D equals `cs_delay`, the outputs are still disabled.
- R7: Whenever `susp_n` is 1, `out_en` is 1 in the same cycle, with no clock edge needed.
- R8: A write during suspend does not restart or change the current count. The new value applies from the next suspend edge. A write in the same cycle as the suspend edge also applies only from the next suspend edge.
- R9: Once low, `out_en` stays low until `susp_n` rises. Strobes while `susp_n` is 1 have no effect on `out_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| slow_tick | input | 1 | One-cycle strobe per slow timing-clock edge |
| susp_n | input | 1 | Active-low suspend request |
| cs_en | input | 1 | Sleep-clock-stop enable setting |
| cs_delay | input | 30 | Sleep-clock-stop delay setting |
| out_en | output | 1 | Active-high enable for the controlled output drivers |

## Verification
Two collisions matter most. The first is a slow-clock strobe that lands in the same cycle as the suspend falling edge. It must not be counted. The second is a register write that lands on that edge. The snapshot must take the old word. The bench drives both on purpose in directed cases. Its random phase also lets strobes and writes fall on the suspend edge by chance. Every cycle, a bench-side cycle model built from R3, R6 and R8 decides whether the edge-cycle strobe is counted and which word was captured, and `out_en` is compared with that model.

// File: rtl/sodt_pkg.sv
package sodt_pkg;
   // Counter organisation chosen per instance
   typedef enum logic {
      CNT_UP   = 1'b0,
      CNT_DOWN = 1'b1
   } cnt_style_e;
endpackage

// File: rtl/sodt_ctl_reg.sv
module sodt_ctl_reg #(
   parameter int          REG_W   = 32,
   parameter int          ADDR_W  = 8,
   parameter logic [7:0]  OFFSET  = 8'h0C
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [REG_W-1:0]  wdata,
   output logic [REG_W-1:0]  rdata,
   output logic [REG_W-1:0]  ctl_q
);
   logic hit;

   assign hit = (addr == ADDR_W'(OFFSET));

   always_ff @(posedge clk) begin
      if (rst)
         ctl_q <= '0;
      else if (wr && hit)
         ctl_q <= wdata;
   end

   assign rdata = hit ? ctl_q : '0;

   AST_WRITE_STORES: assert property (@(posedge clk) disable iff (rst)
      (wr && hit) |=> (ctl_q == $past(wdata))); // R2
   AST_MISS_KEEPS: assert property (@(posedge clk) disable iff (rst)
      (wr && !hit) |=> $stable(ctl_q)); // R2
endmodule

// File: rtl/sodt_edge_arm.sv
module sodt_edge_arm #(
   parameter int DELAY_W = 30
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               susp_n,
   input  logic               ctl_en,
   input  logic [DELAY_W-1:0] ctl_dly,
   input  logic               cs_en,
   input  logic [DELAY_W-1:0] cs_dly,
   output logic               fall,
   output logic               go
);
   logic susp_n_d;
   logic too_late;

   always_ff @(posedge clk) begin
      if (rst)
         susp_n_d <= 1'b1;
      else
         susp_n_d <= susp_n;
   end

   assign fall     = susp_n_d & ~susp_n;
   // Clock stop would freeze the counter first: never disable this period
   assign too_late = cs_en && (ctl_dly > cs_dly);
   assign go       = fall && ctl_en && !too_late;

   AST_FALL_NEEDS_LOW: assert property (@(posedge clk) disable iff (rst)
      fall |=> !$past(susp_n)); // R3
endmodule

// File: rtl/sodt_delay_cnt.sv
module sodt_delay_cnt
   import sodt_pkg::*;
#(
   parameter int         DELAY_W = 30,
   parameter cnt_style_e STYLE   = CNT_UP
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               susp_n,
   input  logic               fall,
   input  logic               go,
   input  logic [DELAY_W-1:0] dly_in,
   input  logic               tick,
   output logic               off_q
);
   logic               armed_q;
   logic [DELAY_W-1:0] cnt_q;
   logic               hit_end;

   generate
      if (STYLE == CNT_UP) begin : g_up
         logic [DELAY_W-1:0] dly_q;

         assign hit_end = (cnt_q == dly_q);

         always_ff @(posedge clk) begin
            if (rst) begin
               cnt_q <= '0;
               dly_q <= '0;
            end else if (!susp_n) begin
               if (fall) begin
                  cnt_q <= '0;
                  dly_q <= dly_in;
               end else if (armed_q && tick && !hit_end) begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
         end

         AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
            armed_q |-> (cnt_q <= dly_q)); // R3
         AST_DLY_FROZEN: assert property (@(posedge clk) disable iff (rst)
            !fall |=> $stable(dly_q)); // R8
      end else begin : g_down
         assign hit_end = (cnt_q == '0);

         always_ff @(posedge clk) begin
            if (rst) begin
               cnt_q <= '0;
            end else if (!susp_n) begin
               if (fall)
                  cnt_q <= dly_in;
               else if (armed_q && tick && !hit_end)
                  cnt_q <= cnt_q - 1'b1;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         armed_q <= 1'b0;
         off_q   <= 1'b0;
      end else if (susp_n) begin
         armed_q <= 1'b0;
         off_q   <= 1'b0;
      end else if (fall) begin
         armed_q <= go;
      end else if (armed_q && tick && hit_end) begin
         armed_q <= 1'b0;
         off_q   <= 1'b1;
      end
   end

   AST_OFF_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
      $rose(off_q) |-> $past(tick)); // R3
   AST_HOLD_OFF: assert property (@(posedge clk) disable iff (rst)
      (off_q && !susp_n) |=> off_q); // R9
   AST_NO_OFF_UNARMED: assert property (@(posedge clk) disable iff (rst)
      (!armed_q && !off_q) |=> !off_q); // R5
endmodule

// File: rtl/sleep_out_disable_timer.sv
module sleep_out_disable_timer
   import sodt_pkg::*;
#(
   parameter int         DELAY_W = 30,
   parameter int         ADDR_W  = 8,
   parameter logic [7:0] OFFSET  = 8'h0C,
   parameter cnt_style_e STYLE   = CNT_UP,
   localparam int        REG_W   = DELAY_W + 2,
   localparam int        EN_BIT  = DELAY_W
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [REG_W-1:0]   bus_wdata,
   output logic [REG_W-1:0]   bus_rdata,
   input  logic               slow_tick,
   input  logic               susp_n,
   input  logic               cs_en,
   input  logic [DELAY_W-1:0] cs_delay,
   output logic               out_en
);
   generate
      if (DELAY_W < 1 || DELAY_W > 30) begin : g_bad_w
         $error("DELAY_W must lie in 1..30");
      end
      if (ADDR_W < 1 || ADDR_W > 8) begin : g_bad_a
         $error("ADDR_W must lie in 1..8");
      end
   endgenerate

   logic [REG_W-1:0] ctl_q;
   logic             fall;
   logic             go;
   logic             off_q;

   sodt_ctl_reg #(
      .REG_W  (REG_W),
      .ADDR_W (ADDR_W),
      .OFFSET (OFFSET)
   ) u_reg (
      .clk   (clk),
      .rst   (rst),
      .wr    (bus_wr),
      .addr  (bus_addr),
      .wdata (bus_wdata),
      .rdata (bus_rdata),
      .ctl_q (ctl_q)
   );

   sodt_edge_arm #(
      .DELAY_W (DELAY_W)
   ) u_arm (
      .clk     (clk),
      .rst     (rst),
      .susp_n  (susp_n),
      .ctl_en  (ctl_q[EN_BIT]),
      .ctl_dly (ctl_q[DELAY_W-1:0]),
      .cs_en   (cs_en),
      .cs_dly  (cs_delay),
      .fall    (fall),
      .go      (go)
   );

   sodt_delay_cnt #(
      .DELAY_W (DELAY_W),
      .STYLE   (STYLE)
   ) u_cnt (
      .clk    (clk),
      .rst    (rst),
      .susp_n (susp_n),
      .fall   (fall),
      .go     (go),
      .dly_in (ctl_q[DELAY_W-1:0]),
      .tick   (slow_tick),
      .off_q  (off_q)
   );

   // Wake path is combinational: no edge needed to re-enable drivers
   assign out_en = susp_n | ~off_q;

   AST_WAKE_IMMEDIATE: assert property (@(posedge clk) disable iff (rst)
      susp_n |-> out_en); // R7
   AST_QUIET_AWAKE: assert property (@(posedge clk) disable iff (rst)
      (susp_n && slow_tick) |=> $past(out_en)); // R9
endmodule

// File: tb/sleep_out_disable_timer_test.sv
module sleep_out_disable_timer_test;
   localparam int CLK_P = 10;
   localparam logic [7:0] OFS = 8'h0C;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = OFS;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        slow_tick = 1'b0;
   logic        susp_n = 1'b1;
   logic        cs_en = 1'b0;
   logic [29:0] cs_delay = '0;
   logic        out_en;

   sleep_out_disable_timer uut (
      .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .slow_tick(slow_tick),
      .susp_n(susp_n), .cs_en(cs_en), .cs_delay(cs_delay), .out_en(out_en)
   );

   always #(CLK_P/2) clk = ~clk;

   int    checks = 0;
   int    errors = 0;
   string req = "R1";

   // Bench cycle model derived from the requirements
   logic [31:0] m_ctl = '0;
   logic        m_prev = 1'b1;
   logic        m_armed = 1'b0;
   logic        m_off = 1'b0;
   int unsigned m_cnt = 0;
   int unsigned m_dly = 0;

   always @(posedge clk) begin
      if (rst) begin
         m_ctl = '0; m_prev = 1'b1; m_armed = 1'b0; m_off = 1'b0;
      end else begin
         if (susp_n) begin
            m_armed = 1'b0; m_off = 1'b0;
         end else if (m_prev) begin
            m_armed = m_ctl[30] && !(cs_en && (m_ctl[29:0] > cs_delay));
            m_cnt = 0; m_dly = m_ctl[29:0];
         end else if (m_armed && slow_tick) begin
            if (m_cnt == m_dly) begin m_off = 1'b1; m_armed = 1'b0; end
            else m_cnt++;
         end
         m_prev = susp_n;
         if (bus_wr && bus_addr == OFS) m_ctl = bus_wdata;
      end
   end

   function automatic logic exp_out();
      return susp_n | ~m_off;
   endfunction

   task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", r, act, exp, $time);
      end
   endtask

   task automatic step(bit tk);
      slow_tick = tk;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0;
      slow_tick = 1'b0;
      chk(req, {31'd0, out_en}, {31'd0, exp_out()});
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      step(1'b0);
      bus_addr = OFS;
   endtask

   task automatic rd_chk(logic [7:0] a, string r);
      bus_addr = a;
      #1;
      chk(r, bus_rdata, (a == OFS) ? m_ctl : 32'd0);
      bus_addr = OFS;
   endtask

   task automatic wake(int n);
      susp_n = 1'b1;
      #1 chk("R7", {31'd0, out_en}, 32'd1);
      for (int i = 0; i < n; i++) step(1'b1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd5150));
      @(negedge clk);
      chk("R1", {31'd0, out_en}, 32'd1);
      step(1'b0); step(1'b0);
      rst = 1'b0;
      step(1'b0);
      req = "R1";
      rd_chk(OFS, "R1");
      chk("R1", bus_rdata, 32'd0);

      // R2: full-width store including spare bit, wrong address ignored
      req = "R2";
      wr(OFS, 32'hBFFF_FFFF);
      rd_chk(OFS, "R2");
      chk("R2", bus_rdata, 32'hBFFF_FFFF);
      wr(8'h10, 32'h1234_5678);
      rd_chk(OFS, "R2");
      rd_chk(8'h10, "R2");

      // R3: D=3, strobe on the suspend edge itself is not counted
      req = "R3";
      wr(OFS, 32'h4000_0003);
      susp_n = 1'b0;
      step(1'b1);
      for (int i = 0; i < 3; i++) step(1'b1);
      chk("R3", {31'd0, out_en}, 32'd1);
      step(1'b1);
      chk("R3", {31'd0, out_en}, 32'd0);
      req = "R9";
      for (int i = 0; i < 5; i++) step(i[0]);
      chk("R9", {31'd0, out_en}, 32'd0);
      wake(3);

      // R4: zero delay, first counted strobe
      req = "R4";
      wr(OFS, 32'h4000_0000);
      susp_n = 1'b0;
      step(1'b0); step(1'b0);
      chk("R4", {31'd0, out_en}, 32'd1);
      step(1'b1);
      chk("R4", {31'd0, out_en}, 32'd0);
      wake(2);

      // R5: enable bit clear
      req = "R5";
      wr(OFS, 32'h8000_0001);
      susp_n = 1'b0;
      for (int i = 0; i < 8; i++) step(1'b1);
      chk("R5", {31'd0, out_en}, 32'd1);
      wake(2);

      // R6: suppression when delay exceeds clock-stop delay, not when equal
      req = "R6";
      cs_en = 1'b1; cs_delay = 30'd2;
      wr(OFS, 32'h4000_0003);
      susp_n = 1'b0;
      for (int i = 0; i < 8; i++) step(1'b1);
      chk("R6", {31'd0, out_en}, 32'd1);
      wake(2);
      wr(OFS, 32'h4000_0002);
      susp_n = 1'b0;
      for (int i = 0; i < 4; i++) step(1'b1);
      chk("R6", {31'd0, out_en}, 32'd0);
      wake(2);
      cs_en = 1'b0;

      // R8: write mid-count and write on the suspend edge
      req = "R8";
      wr(OFS, 32'h4000_0004);
      susp_n = 1'b0;
      step(1'b1);
      step(1'b1); step(1'b1);
      wr(OFS, 32'h4000_0000);
      chk("R8", {31'd0, out_en}, 32'd1);
      step(1'b1); step(1'b1);
      chk("R8", {31'd0, out_en}, 32'd1);
      step(1'b1);
      chk("R8", {31'd0, out_en}, 32'd0);
      wake(2);
      susp_n = 1'b0;
      bus_wr = 1'b1; bus_wdata = 32'h4000_0005;
      step(1'b1);
      step(1'b1);
      chk("R8", {31'd0, out_en}, 32'd0);
      wake(2);

      // R9: strobes while awake do nothing
      req = "R9";
      for (int i = 0; i < 6; i++) step(1'b1);
      chk("R9", {31'd0, out_en}, 32'd1);

      // Random mix, judged every cycle by the model
      for (int ep = 0; ep < 60; ep++) begin
         req = "R3";
         wr(OFS, {$urandom_range(1), ($urandom_range(3) != 0) ? 1'b1 : 1'b0,
                  30'($urandom_range(12))});
         cs_en = $urandom_range(1);
         cs_delay = 30'($urandom_range(12));
         susp_n = 1'b0;
         for (int c = 0; c < int'($urandom_range(40)); c++) begin
            if ($urandom_range(9) == 0) begin
               req = "R8";
               bus_wr = 1'b1;
               bus_addr = ($urandom_range(3) == 0) ? 8'h08 : OFS;
               bus_wdata = $urandom;
            end
            step($urandom_range(2) == 0);
            bus_addr = OFS;
         end
         rd_chk(OFS, "R2");
         wake(int'($urandom_range(4)));
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule